// File: doc/BRIEF.md
# Wrap-Aware Comparator Timer Channel

This block is one event-timer channel. It watches a free-running 64-bit main counter that lives outside the block and raises a one-clock `fire` pulse toward the interrupt logic when the counter reaches a programmed comparator value. The channel runs in one-shot or periodic mode. A 32-bit compatibility mode makes every comparison, reload and wrap check use only the low half of the counter.

Software loads the comparator through two 32-bit half-write strobes. In periodic mode these writes normally go to a hidden period register. A one-shot "load comparator" flag (`setval_req`) lets a single half-write reach the comparator as well.

On each periodic expiry the channel adds the period to the comparator, one addition per clock, until the comparator is ahead of the counter again. In 32-bit one-shot mode, when the match lies beyond the next rollover of the low counter half, the channel fires once at the rollover and again at the match.

The counter owner sends `cnt_tick` in the cycle where `cnt_val` takes a new value. The channel evaluates expiry only on those cycles. There is no streaming data path: every pin is a plain level or a one-cycle strobe.

Top module: `cmpt_channel`

## Requirements
- R1: After reset, `fire` is 0 and `cmp_rd` reads all ones (64'hFFFF_FFFF_FFFF_FFFF). The hidden period is zero and the wrap flag is clear.
- R2: An armed channel with `glb_en` and `ch_en` high fires when a tick finds the comparator not ahead of the counter. "Ahead" means the wrap-around difference cmp−cnt is positive as a signed number. `fire` is high in the clock after the tick cycle. In one-shot mode the channel then disarms and does not fire again.
- R3: In periodic mode with a nonzero period, each expiry fires once. The comparator is then advanced by the period, one addition per clock, until it is ahead of the counter. No fire occurs during this catch-up.
- R4: In 32-bit mode (`cfg_mode32`=1) the ahead test uses only bits 31:0 of the comparator and counter, so counter bits 63:32 have no effect. Otherwise it uses all 64 bits.
- R5: In 32-bit one-shot mode, if at arming the comparator's low half is numerically below the counter's low half but still ahead of it, the channel fires at the tick where the counter's low half becomes 0. It fires again at the real match.
- R6: A half-write updates that half of the comparator when the channel is in one-shot mode or the load flag is set. In periodic mode without the flag, the comparator is unchanged and the value goes to the period. Any half-write (`wr_lo` for bits 31:0, `wr_hi` for bits 63:32) clears the load flag.
- R7: A value stored as period has its top bit cleared: bit 63 on upper-half writes, and bit 31 on lower-half writes in 32-bit mode.
- R8: When `cfg_mode32` rises, comparator and period bits 63:32 become 0. While in 32-bit mode, upper-half writes leave the comparator's upper half at 0.
- R9: A rise of `glb_en` arms the channel only if the comparator is not all ones. A rise of `ch_en` while `glb_en` is high arms it. Any half-write while `glb_en` is high re-arms it. Every arming clears the wrap flag before re-evaluating it.
- R10: A fall of `ch_en` or of `glb_en` cancels any pending expiry. No fire occurs while either enable is low.
- R11: `fire` is never high for two consecutive clocks.
- R12: In periodic mode with a zero period, an expiry fires once and the channel then behaves as one-shot: it disarms and leaves the comparator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | High in the cycle where `cnt_val` takes a new value |
| cnt_val | input | 64 | Main counter value |
| glb_en | input | 1 | Global enable for counting and interrupts |
| ch_en | input | 1 | Channel enable |
| cfg_periodic | input | 1 | 1 = periodic mode, 0 = one-shot |
| cfg_mode32 | input | 1 | 1 = 32-bit compatibility mode |
| setval_req | input | 1 | Strobe that sets the comparator-load flag |
| wr_lo | input | 1 | Write strobe for bits 31:0 |
| wr_hi | input | 1 | Write strobe for bits 63:32 |
| wr_data | input | 32 | Write data for the selected half |
| fire | output | 1 | One-clock expiry pulse |
| cmp_rd | output | 64 | Current comparator value |

## Verification
The assertions assume that `cnt_tick` never occurs on two consecutive clocks. They also assume that half-writes and `setval_req` do not coincide with a tick or with each other. Without this spacing, a wrap fire followed at once by a match could produce back-to-back pulses, and a catch-up could still be running when the next tick arrives. The bench drives every tick, write and enable change as a separate strobe followed by several idle clocks. Counter jumps are small enough that the catch-up finishes within those idle clocks.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned HALF_W = CNT_W / 2;
endpackage

// File: rtl/cmpt_ahead.sv
module cmpt_ahead #(
  parameter int unsigned CNT_W = cmpt_pkg::CNT_W
) (
  input  logic [CNT_W-1:0] a_cmp,
  input  logic [CNT_W-1:0] a_cnt,
  input  logic             narrow,
  output logic             ahead
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] diff;

  assign diff  = a_cmp - a_cnt;
  // positive signed difference at the selected width
  assign ahead = narrow ? (!diff[HALF_W-1] && (diff[HALF_W-1:0] != '0))
                        : (!diff[CNT_W-1]  && (diff != '0));
endmodule

// File: rtl/cmpt_regs.sv
module cmpt_regs #(
  parameter int unsigned CNT_W = cmpt_pkg::CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode32,
  input  logic                  periodic,
  input  logic                  setval_req,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [CNT_W/2-1:0]    wr_data,
  input  logic                  adv,
  output logic [CNT_W-1:0]      cmp_q,
  output logic [CNT_W-1:0]      cmp_wr,
  output logic                  period_nz
);
  localparam int unsigned HALF_W = CNT_W / 2;
  localparam logic [HALF_W-1:0] CLAMP = {1'b0, {(HALF_W-1){1'b1}}};

  logic [CNT_W-1:0] period_q, per_n, cmp_n;
  logic             setval_q, m32_q, load_cmp, m32_rise;
  logic [HALF_W-1:0] lo_mask;

  assign load_cmp = !periodic || setval_q;
  assign m32_rise = mode32 && !m32_q;
  assign lo_mask  = mode32 ? CLAMP : '1;

  always_comb begin
    cmp_wr = cmp_q;
    per_n  = period_q;
    if (wr_lo) begin
      if (load_cmp) cmp_wr[HALF_W-1:0] = wr_data;
      if (periodic) per_n[HALF_W-1:0]  = wr_data & lo_mask;
    end
    if (wr_hi && !mode32) begin
      if (load_cmp) cmp_wr[CNT_W-1:HALF_W] = wr_data;
      else          per_n[CNT_W-1:HALF_W]  = wr_data & CLAMP;
    end
    if (m32_rise) begin
      cmp_wr[CNT_W-1:HALF_W] = '0;
      per_n[CNT_W-1:HALF_W]  = '0;
    end
  end

  always_comb begin
    cmp_n = cmp_wr;
    if (adv) begin
      if (mode32) cmp_n = {{HALF_W{1'b0}}, cmp_q[HALF_W-1:0] + period_q[HALF_W-1:0]};
      else        cmp_n = cmp_q + period_q;
    end
  end

  assign period_nz = |period_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '1;
      period_q <= '0;
      setval_q <= 1'b0;
      m32_q    <= 1'b0;
    end else begin
      cmp_q    <= cmp_n;
      period_q <= per_n;
      m32_q    <= mode32;
      if (wr_lo || wr_hi) setval_q <= 1'b0;
      else if (setval_req) setval_q <= 1'b1;
    end
  end

  // R6
  setval_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> !setval_q);
  // R7
  period_halfrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_q[CNT_W-1]);
  // R8
  mode32_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode32 |=> (cmp_q[CNT_W-1:HALF_W] == '0));
endmodule

// File: rtl/cmpt_ctrl.sv
module cmpt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_tick,
  input  logic cnt_lo_zero,
  input  logic ahead_now,
  input  logic ahead_wr,
  input  logic cmp_lo_below,
  input  logic cmp_all_ones,
  input  logic glb_en,
  input  logic ch_en,
  input  logic periodic,
  input  logic mode32,
  input  logic period_nz,
  input  logic wr_any,
  output logic adv,
  output logic fire
);
  logic glb_q, ch_q, armed_q, wrap_q, catch_q, fire_q;
  logic cancel, arm_req, live, wrap_hit, match_hit, hold, reload, fire_d;

  assign cancel    = (glb_q && !glb_en) || (ch_q && !ch_en);
  assign arm_req   = (wr_any && glb_en) || (glb_en && !glb_q && !cmp_all_ones)
                   || (ch_en && !ch_q && glb_en);
  assign live      = cnt_tick && armed_q && glb_en && ch_en;
  assign wrap_hit  = live && wrap_q && cnt_lo_zero;
  assign match_hit = live && !wrap_hit && !ahead_now;
  assign hold      = cancel || arm_req;
  assign reload    = periodic && period_nz;
  assign adv       = !hold && (catch_q ? !ahead_now : (match_hit && reload));
  assign fire_d    = !hold && !catch_q && (wrap_hit || match_hit);
  assign fire      = fire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q   <= 1'b0;
      ch_q    <= 1'b0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      catch_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      glb_q  <= glb_en;
      ch_q   <= ch_en;
      fire_q <= fire_d;
      if (cancel) begin
        armed_q <= 1'b0;
        catch_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm_req) begin
        armed_q <= 1'b1;
        catch_q <= 1'b0;
        wrap_q  <= mode32 && !periodic && cmp_lo_below && ahead_wr;
      end else if (catch_q) begin
        if (ahead_now) catch_q <= 1'b0;
      end else if (wrap_hit) begin
        wrap_q <= 1'b0;
      end else if (match_hit) begin
        if (reload) catch_q <= 1'b1;
        else        armed_q <= 1'b0;
      end
    end
  end

  // R11
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  // R10
  cancel_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((glb_q && !glb_en) || (ch_q && !ch_en)) |=> !armed_q);
  // R3
  catchup_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    catch_q |=> !fire_q);
endmodule

// File: rtl/cmpt_channel.sv
module cmpt_channel #(
  parameter int unsigned CNT_W = cmpt_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_tick,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               glb_en,
  input  logic               ch_en,
  input  logic               cfg_periodic,
  input  logic               cfg_mode32,
  input  logic               setval_req,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic               fire,
  output logic [CNT_W-1:0]   cmp_rd
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cmp_q, cmp_wr;
  logic period_nz, adv, ahead_now, ahead_wr;

  cmpt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode32(cfg_mode32), .periodic(cfg_periodic),
    .setval_req(setval_req), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .adv(adv), .cmp_q(cmp_q), .cmp_wr(cmp_wr), .period_nz(period_nz)
  );

  cmpt_ahead #(.CNT_W(CNT_W)) u_ahead_now (
    .a_cmp(cmp_q), .a_cnt(cnt_val), .narrow(cfg_mode32), .ahead(ahead_now)
  );

  cmpt_ahead #(.CNT_W(CNT_W)) u_ahead_wr (
    .a_cmp(cmp_wr), .a_cnt(cnt_val), .narrow(cfg_mode32), .ahead(ahead_wr)
  );

  cmpt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .cnt_lo_zero(cnt_val[HALF_W-1:0] == '0),
    .ahead_now(ahead_now), .ahead_wr(ahead_wr),
    .cmp_lo_below(cmp_wr[HALF_W-1:0] < cnt_val[HALF_W-1:0]),
    .cmp_all_ones(&cmp_q),
    .glb_en(glb_en), .ch_en(ch_en), .periodic(cfg_periodic), .mode32(cfg_mode32),
    .period_nz(period_nz), .wr_any(wr_lo || wr_hi), .adv(adv), .fire(fire)
  );

  assign cmp_rd = cmp_q;
endmodule

// File: tb/tb_cmpt_channel.sv
`timescale 1ns/1ps
module tb_cmpt_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0;
  logic [63:0] cnt_val = '0;
  logic        glb_en = 1'b0, ch_en = 1'b0, cfg_periodic = 1'b0, cfg_mode32 = 1'b0;
  logic        setval_req = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic        fire;
  logic [63:0] cmp_rd;

  int checks = 0, failures = 0, fires = 0, long_pulses = 0;
  logic prev_fire = 1'b0;

  always #2.5 clk = ~clk;

  cmpt_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .glb_en(glb_en), .ch_en(ch_en), .cfg_periodic(cfg_periodic),
    .cfg_mode32(cfg_mode32), .setval_req(setval_req), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .fire(fire), .cmp_rd(cmp_rd)
  );

  always @(negedge clk) begin
    if (fire) fires++;
    if (fire && prev_fire) long_pulses++;
    prev_fire <= fire;
  end

  // fields: periodic, setval, upper half, data, expected comparator
  localparam logic [98:0] TBL [7] = '{
    {1'b0, 1'b0, 1'b0, 32'h0000_0010, 64'hFFFF_FFFF_0000_0010},
    {1'b0, 1'b0, 1'b1, 32'h0000_0000, 64'h0000_0000_0000_0010},
    {1'b1, 1'b0, 1'b0, 32'h0000_0005, 64'h0000_0000_0000_0010},
    {1'b1, 1'b1, 1'b0, 32'h0000_0020, 64'h0000_0000_0000_0020},
    {1'b1, 1'b0, 1'b1, 32'h0000_1234, 64'h0000_0000_0000_0020},
    {1'b1, 1'b1, 1'b1, 32'h0000_0001, 64'h0000_0001_0000_0020},
    {1'b1, 1'b0, 1'b0, 32'h0000_0007, 64'h0000_0001_0000_0020}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_to(input logic [63:0] v);
    @(negedge clk);
    cnt_val = v;
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    idle(4);
  endtask

  task automatic write_half(input logic hi, input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    wr_lo = !hi;
    wr_hi = hi;
    @(negedge clk);
    wr_lo = 1'b0;
    wr_hi = 1'b0;
    idle(1);
  endtask

  task automatic set_load_flag();
    @(negedge clk);
    setval_req = 1'b1;
    @(negedge clk);
    setval_req = 1'b0;
  endtask

  task automatic set_glb(input logic v);
    @(negedge clk);
    glb_en = v;
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 fire", {63'b0, fire}, 64'd0);
    chk("R1 cmp", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);

    // R9 glb rise with all-ones comparator does not arm
    @(negedge clk); ch_en = 1'b1; idle(2);
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'd1);
    tick_to(64'd2);
    chk("R9 no arm on all-ones", 64'(fires - f0), 64'd0);
    set_glb(1'b0);

    // R6 write path table
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); cfg_periodic = TBL[i][98];
      if (TBL[i][97]) set_load_flag();
      write_half(TBL[i][96], TBL[i][95:64]);
      chk($sformatf("R6 entry %0d", i), cmp_rd, TBL[i][63:0]);
    end

    // R2 one-shot
    @(negedge clk); cfg_periodic = 1'b0;
    write_half(1'b1, 32'd0);
    write_half(1'b0, 32'd105);
    cnt_val = 64'd100;
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'd101);
    tick_to(64'd104);
    chk("R2 before match", 64'(fires - f0), 64'd0);
    tick_to(64'd105);
    chk("R2 at match", 64'(fires - f0), 64'd1);
    tick_to(64'd106);
    tick_to(64'd107);
    chk("R2 one-shot disarmed", 64'(fires - f0), 64'd1);

    // R10 cancel
    set_glb(1'b0);
    write_half(1'b0, 32'd203);
    cnt_val = 64'd200;
    set_glb(1'b1);
    @(negedge clk); ch_en = 1'b0; idle(2);
    f0 = fires;
    tick_to(64'd201);
    tick_to(64'd205);
    chk("R10 ch_en low cancels", 64'(fires - f0), 64'd0);
    @(negedge clk); ch_en = 1'b1; idle(2);
    tick_to(64'd206);
    chk("R9 ch_en rise rearms", 64'(fires - f0), 64'd1);
    set_glb(1'b0);
    write_half(1'b0, 32'd210);
    f0 = fires;
    tick_to(64'd210);
    chk("R10 glb_en low no fire", 64'(fires - f0), 64'd0);

    // R3 periodic with catch-up
    @(negedge clk); cfg_periodic = 1'b1;
    set_load_flag();
    write_half(1'b0, 32'd1010);
    write_half(1'b0, 32'd10);
    write_half(1'b1, 32'd0);
    chk("R6 periodic load", cmp_rd, 64'd1010);
    cnt_val = 64'd1000;
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'd1010);
    chk("R3 first expiry", 64'(fires - f0), 64'd1);
    chk("R3 reload", cmp_rd, 64'd1020);
    tick_to(64'd1015);
    tick_to(64'd1020);
    chk("R3 second expiry", 64'(fires - f0), 64'd2);
    tick_to(64'd1055);
    chk("R3 catch-up single fire", 64'(fires - f0), 64'd3);
    chk("R3 catch-up value", cmp_rd, 64'd1060);

    // R12 periodic with zero period
    set_glb(1'b0);
    set_load_flag();
    write_half(1'b0, 32'd1100);
    write_half(1'b0, 32'd0);
    cnt_val = 64'd1090;
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'd1100);
    tick_to(64'd1101);
    tick_to(64'd1102);
    chk("R12 single fire", 64'(fires - f0), 64'd1);
    chk("R12 comparator kept", cmp_rd, 64'd1100);

    // R8 mode32 truncation
    set_glb(1'b0);
    @(negedge clk); cfg_periodic = 1'b0;
    write_half(1'b1, 32'd5);
    chk("R8 before", cmp_rd, 64'h0000_0005_0000_044C);
    @(negedge clk); cfg_mode32 = 1'b1; idle(2);
    chk("R8 truncated", cmp_rd, 64'h0000_0000_0000_044C);
    write_half(1'b1, 32'd9);
    chk("R8 upper write in 32-bit", cmp_rd, 64'h0000_0000_0000_044C);

    // R7 period clamp in 32-bit mode
    @(negedge clk); cfg_periodic = 1'b1;
    set_load_flag();
    write_half(1'b0, 32'h100);
    write_half(1'b0, 32'hFFFF_FFFF);
    cnt_val = 64'hF0;
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'h100);
    chk("R7 fire", 64'(fires - f0), 64'd1);
    chk("R7 clamped reload", cmp_rd, 64'h0000_0000_8000_00FF);

    // R4 32-bit compare ignores upper counter
    set_glb(1'b0);
    @(negedge clk); cfg_periodic = 1'b0;
    write_half(1'b0, 32'h105);
    cnt_val = 64'h5_0000_0100;
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'h5_0000_0101);
    chk("R4 no early fire", 64'(fires - f0), 64'd0);
    tick_to(64'h5_0000_0105);
    chk("R4 low-half match", 64'(fires - f0), 64'd1);

    // R5 wrap fire
    set_glb(1'b0);
    write_half(1'b0, 32'd3);
    cnt_val = 64'hFFFF_FFFC;
    set_glb(1'b1);
    f0 = fires;
    tick_to(64'hFFFF_FFFD);
    tick_to(64'hFFFF_FFFE);
    tick_to(64'hFFFF_FFFF);
    chk("R5 before rollover", 64'(fires - f0), 64'd0);
    tick_to(64'h1_0000_0000);
    chk("R5 rollover fire", 64'(fires - f0), 64'd1);
    tick_to(64'h1_0000_0001);
    tick_to(64'h1_0000_0002);
    chk("R5 no fire before match", 64'(fires - f0), 64'd1);
    tick_to(64'h1_0000_0003);
    chk("R5 match fire", 64'(fires - f0), 64'd2);

    // R11 pulse width
    chk("R11 single-cycle pulses", 64'(long_pulses), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule